// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block tracks which cache lines currently hold a load-linked reservation for one core, and decides the outcome of each store-conditional. Every reservation entry holds a line address and the identifier of the thread (owner) that placed it. The cache controller reports each completing access with its line address, access kind, owner and whether the line was found in the cache. One cycle later the block returns a success flag, a data commit enable and a status word for the requester.

The coherence side can signal at any time that write permission on a line has been lost. Any reservation on that line is then dropped. Store-conditionals always consume the reservation on their line, and ordinary stores by the reserving owner drop it. When the table is full, a new load-linked evicts the entry that was set least recently.

Top module: `llsc_monitor`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rsp_valid` is 0 and no reservation is held; a store-conditional issued right after reset fails.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `cmp_valid` high, and low otherwise.
- R3: A load-linked (`cmp_kind` = 1) to a present line reserves that line for `cmp_owner` and answers success 1, commit 0, status 0.
- R4: A store-conditional (`cmp_kind` = 2) to a present line succeeds only when the line is reserved by the same owner. It then answers success 1, commit 1, status 1. Otherwise it answers success 0, commit 0, status 0.
- R5: A store-conditional to a present line removes any reservation on that line, whether it succeeds or fails and whichever owner holds it.
- R6: An ordinary store (`cmp_kind` = 3) to a present line answers success 1, commit 1, status 0. It removes the reservation on that line only when the reservation belongs to the same owner.
- R7: A permission-loss notice removes the reservation on `loss_line`. When it arrives in the same cycle as a completion, it takes effect before that completion is judged.
- R8: A completion with `cmp_line_present` low changes no reservation. It answers success 1, and commit 1 only for kinds 2 and 3. The status is 1 only for kind 2.
- R9: A plain read (`cmp_kind` = 0) answers success 1, commit 0, status 0 and changes no reservation.
- R10: At most one entry holds a given line. A load-linked to a line already reserved re-tags it with the new owner and makes it the newest entry.
- R11: The table holds `N_RES` entries. A load-linked to a new line with all entries in use replaces the entry set least recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_valid | input | 1 | An access completes this cycle |
| cmp_kind | input | 2 | 0 read, 1 load-linked, 2 store-conditional, 3 store |
| cmp_line | input | ADDR_W | Line address of the completion |
| cmp_owner | input | OWNER_W | Owner (thread) identifier of the completion |
| cmp_line_present | input | 1 | The cache lookup found the line |
| loss_valid | input | 1 | Permission on a line was lost this cycle |
| loss_line | input | ADDR_W | Line whose permission was lost |
| rsp_valid | output | 1 | Verdict valid (one cycle after completion) |
| rsp_success | output | 1 | Operation succeeded |
| rsp_commit | output | 1 | Store data may be written to the line |
| rsp_status | output | STAT_W | Value returned to the requester: 1 for a successful store-conditional, otherwise 0 |

## Verification
Directed pairs first show that a store-conditional succeeds only after a matching load-linked. They also show it fails after any intervening clear: a second store-conditional, an own-owner store, a permission loss, or a loss that arrives in the same cycle. Mismatched-owner sequences separate the owner check from the line check. Stores by a foreign owner, reads and absent lines show that a reservation survives them. Eviction runs fill the table, some with a refreshed entry in between, so that the entry chosen for replacement is the least recently set one and not simply the lowest index. A long stretch of mixed traffic over a few lines and owners then exercises overlapping clears and replacement against the reference queue.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_LL    = 2'd1,
        ACC_SC    = 2'd2,
        ACC_STORE = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic success;
        logic commit;
        logic status_ok;
    } llsc_verdict_t;

    // Outcome of one completion, given whether the line was found and
    // whether this owner still holds the reservation on it.
    function automatic llsc_verdict_t judge(input acc_kind_e kind,
                                            input logic present,
                                            input logic reserved_own);
        llsc_verdict_t v;
        v.success   = 1'b1;
        v.commit    = 1'b0;
        v.status_ok = 1'b0;
        if (!present) begin
            v.commit    = (kind == ACC_SC) || (kind == ACC_STORE);
            v.status_ok = (kind == ACC_SC);
        end else begin
            case (kind)
                ACC_SC: begin
                    v.success   = reserved_own;
                    v.commit    = reserved_own;
                    v.status_ok = reserved_own;
                end
                ACC_STORE: v.commit = 1'b1;
                default: ;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/llsc_match.sv
module llsc_match #(
    parameter int N_RES  = 4,
    parameter int ADDR_W = 26
) (
    input  logic [N_RES-1:0]             ent_valid,
    input  logic [N_RES-1:0][ADDR_W-1:0] ent_line,
    input  logic [ADDR_W-1:0]            probe_line,
    output logic [N_RES-1:0]             line_hit
);
    for (genvar g = 0; g < N_RES; g++) begin : g_cmp
        assign line_hit[g] = ent_valid[g] && (ent_line[g] == probe_line);
    end
endmodule

// File: rtl/llsc_table.sv
module llsc_table #(
    parameter int N_RES   = 4,
    parameter int ADDR_W  = 26,
    parameter int OWNER_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [N_RES-1:0]              clr_vec,
    input  logic                          set_en,
    input  logic [N_RES-1:0]              set_hit,
    input  logic [ADDR_W-1:0]             set_line,
    input  logic [OWNER_W-1:0]            set_owner,
    output logic [N_RES-1:0]              ent_valid,
    output logic [N_RES-1:0][ADDR_W-1:0]  ent_line,
    output logic [N_RES-1:0][OWNER_W-1:0] ent_owner
);
    localparam int RANK_W = (N_RES > 1) ? $clog2(N_RES) : 1;
    localparam logic [RANK_W-1:0] RANK_MAX = RANK_W'(N_RES - 1);

    // rank 0 = most recently set; valid entries always hold ranks 0..count-1
    logic [N_RES-1:0][RANK_W-1:0]  rank_q, rank_a, rank_d;
    logic [N_RES-1:0]              surv, tgt, valid_d;
    logic [N_RES-1:0][ADDR_W-1:0]  line_d;
    logic [N_RES-1:0][OWNER_W-1:0] owner_d;
    logic                          free_found, tgt_live;
    logic [RANK_W-1:0]             tgt_rank;

    always_comb begin
        surv = ent_valid & ~clr_vec;
        // compact ranks after clears
        for (int e = 0; e < N_RES; e++) begin
            rank_a[e] = '0;
            for (int j = 0; j < N_RES; j++) begin
                if (surv[j] && (rank_q[j] < rank_q[e]))
                    rank_a[e] = rank_a[e] + RANK_W'(1);
            end
        end
        // target: existing line, else lowest free slot, else the oldest
        tgt        = '0;
        free_found = 1'b0;
        if (|set_hit) begin
            tgt = set_hit;
        end else begin
            for (int e = 0; e < N_RES; e++) begin
                if (!surv[e] && !free_found) begin
                    tgt[e]     = 1'b1;
                    free_found = 1'b1;
                end
            end
            if (!free_found) begin
                for (int e = 0; e < N_RES; e++)
                    if (rank_a[e] == RANK_MAX) tgt[e] = 1'b1;
            end
        end
        tgt_live = |(tgt & surv);
        tgt_rank = '0;
        for (int e = 0; e < N_RES; e++)
            if (tgt[e]) tgt_rank = tgt_rank | rank_a[e];

        valid_d = surv;
        line_d  = ent_line;
        owner_d = ent_owner;
        rank_d  = rank_a;
        if (set_en) begin
            for (int e = 0; e < N_RES; e++) begin
                if (tgt[e]) begin
                    valid_d[e] = 1'b1;
                    line_d[e]  = set_line;
                    owner_d[e] = set_owner;
                    rank_d[e]  = '0;
                end else if (surv[e] && (!tgt_live || rank_a[e] < tgt_rank)) begin
                    rank_d[e] = rank_a[e] + RANK_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_valid <= '0;
            ent_line  <= '0;
            ent_owner <= '0;
            rank_q    <= '0;
        end else begin
            ent_valid <= valid_d;
            ent_line  <= line_d;
            ent_owner <= owner_d;
            rank_q    <= rank_d;
        end
    end
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp
    import llsc_mon_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  llsc_verdict_t     in_verdict,
    output logic              rsp_valid,
    output logic              rsp_success,
    output logic              rsp_commit,
    output logic [STAT_W-1:0] rsp_status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_success <= 1'b0;
            rsp_commit  <= 1'b0;
            rsp_status  <= '0;
        end else begin
            rsp_valid   <= in_valid;
            rsp_success <= in_valid && in_verdict.success;
            rsp_commit  <= in_valid && in_verdict.commit;
            rsp_status  <= STAT_W'(in_valid && in_verdict.status_ok);
        end
    end
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_mon_pkg::*;
#(
    parameter int N_RES   = 4,
    parameter int ADDR_W  = 26,
    parameter int OWNER_W = 4,
    parameter int STAT_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmp_valid,
    input  logic [1:0]         cmp_kind,
    input  logic [ADDR_W-1:0]  cmp_line,
    input  logic [OWNER_W-1:0] cmp_owner,
    input  logic               cmp_line_present,
    input  logic               loss_valid,
    input  logic [ADDR_W-1:0]  loss_line,
    output logic               rsp_valid,
    output logic               rsp_success,
    output logic               rsp_commit,
    output logic [STAT_W-1:0]  rsp_status
);
    acc_kind_e                     kind;
    logic [N_RES-1:0]              ent_valid;
    logic [N_RES-1:0][ADDR_W-1:0]  ent_line;
    logic [N_RES-1:0][OWNER_W-1:0] ent_owner;
    logic [N_RES-1:0]              loss_hit_raw, cmp_hit_raw;
    logic [N_RES-1:0]              loss_vec, cmp_hit, owner_eq, own_hit, clr_vec;
    logic                          act, set_en;
    llsc_verdict_t                 verdict;

    assign kind = acc_kind_e'(cmp_kind);

    llsc_match #(.N_RES(N_RES), .ADDR_W(ADDR_W)) u_loss_match (
        .ent_valid (ent_valid),
        .ent_line  (ent_line),
        .probe_line(loss_line),
        .line_hit  (loss_hit_raw)
    );

    llsc_match #(.N_RES(N_RES), .ADDR_W(ADDR_W)) u_cmp_match (
        .ent_valid (ent_valid),
        .ent_line  (ent_line),
        .probe_line(cmp_line),
        .line_hit  (cmp_hit_raw)
    );

    for (genvar g = 0; g < N_RES; g++) begin : g_owner
        assign owner_eq[g] = (ent_owner[g] == cmp_owner);
    end

    // permission loss is applied before the completion is judged (R7)
    assign loss_vec = loss_valid ? loss_hit_raw : '0;
    assign cmp_hit  = cmp_hit_raw & ~loss_vec;
    assign own_hit  = cmp_hit & owner_eq;
    assign act      = cmp_valid && cmp_line_present;
    assign verdict  = judge(kind, cmp_line_present, |own_hit);
    assign set_en   = act && (kind == ACC_LL);
    assign clr_vec  = loss_vec
                    | ((act && kind == ACC_SC)    ? cmp_hit : '0)
                    | ((act && kind == ACC_STORE) ? own_hit : '0);

    llsc_table #(.N_RES(N_RES), .ADDR_W(ADDR_W), .OWNER_W(OWNER_W)) u_table (
        .clk      (clk),
        .rst      (rst),
        .clr_vec  (clr_vec),
        .set_en   (set_en),
        .set_hit  (cmp_hit),
        .set_line (cmp_line),
        .set_owner(cmp_owner),
        .ent_valid(ent_valid),
        .ent_line (ent_line),
        .ent_owner(ent_owner)
    );

    llsc_resp #(.STAT_W(STAT_W)) u_resp (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (cmp_valid),
        .in_verdict (verdict),
        .rsp_valid  (rsp_valid),
        .rsp_success(rsp_success),
        .rsp_commit (rsp_commit),
        .rsp_status (rsp_status)
    );
endmodule

// File: rtl/llsc_monitor_chk.sv
module llsc_monitor_chk #(
    parameter int N_RES  = 4,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmp_valid,
    input logic [1:0]        cmp_kind,
    input logic              cmp_line_present,
    input logic              loss_valid,
    input logic              rsp_valid,
    input logic              rsp_success,
    input logic              rsp_commit,
    input logic [STAT_W-1:0] rsp_status,
    input logic [N_RES-1:0]  ent_valid,
    input logic [N_RES-1:0]  cmp_hit_raw
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!rsp_valid && ent_valid == '0));

    a_r2_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> !rsp_valid);

    a_r3_ll_no_commit: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'd1) |=> (rsp_success && !rsp_commit && rsp_status == '0));

    a_r4_fail_no_commit: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_success) |-> (!rsp_commit && rsp_status == '0));

    a_r4_status_means_success: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_status != '0) |-> (rsp_success && rsp_commit && rsp_status == STAT_W'(1)));

    a_r6_store_commits: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'd3) |=> (rsp_success && rsp_commit && rsp_status == '0));

    a_r8_absent_success: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_line_present) |=> rsp_success);

    a_r8_absent_keeps: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !cmp_line_present && !loss_valid) |=> $stable(ent_valid));

    a_r9_read_no_commit: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && cmp_kind == 2'd0) |=> (rsp_success && !rsp_commit));

    a_r10_one_entry_per_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmp_hit_raw));
endmodule

bind llsc_monitor llsc_monitor_chk #(.N_RES(N_RES), .STAT_W(STAT_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .cmp_valid       (cmp_valid),
    .cmp_kind        (cmp_kind),
    .cmp_line_present(cmp_line_present),
    .loss_valid      (loss_valid),
    .rsp_valid       (rsp_valid),
    .rsp_success     (rsp_success),
    .rsp_commit      (rsp_commit),
    .rsp_status      (rsp_status),
    .ent_valid       (ent_valid),
    .cmp_hit_raw     (cmp_hit_raw)
);

// File: tb/llsc_monitor_tb_top.sv
module llsc_monitor_tb_top;
    localparam int N_RES   = 4;
    localparam int ADDR_W  = 26;
    localparam int OWNER_W = 4;
    localparam int STAT_W  = 8;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmp_valid = 1'b0;
    logic [1:0]         cmp_kind = '0;
    logic [ADDR_W-1:0]  cmp_line = '0;
    logic [OWNER_W-1:0] cmp_owner = '0;
    logic               cmp_line_present = 1'b0;
    logic               loss_valid = 1'b0;
    logic [ADDR_W-1:0]  loss_line = '0;
    logic               rsp_valid, rsp_success, rsp_commit;
    logic [STAT_W-1:0]  rsp_status;

    always #5 clk = ~clk;

    llsc_monitor #(.N_RES(N_RES), .ADDR_W(ADDR_W), .OWNER_W(OWNER_W), .STAT_W(STAT_W)) dut_i (
        .clk(clk), .rst(rst), .cmp_valid(cmp_valid), .cmp_kind(cmp_kind),
        .cmp_line(cmp_line), .cmp_owner(cmp_owner), .cmp_line_present(cmp_line_present),
        .loss_valid(loss_valid), .loss_line(loss_line), .rsp_valid(rsp_valid),
        .rsp_success(rsp_success), .rsp_commit(rsp_commit), .rsp_status(rsp_status)
    );

    // ---------------- reference model: ordered queue, oldest first ----------------
    typedef struct {
        logic [ADDR_W-1:0]  line;
        logic [OWNER_W-1:0] owner;
    } resv_t;
    resv_t mq[$];

    logic              exp_valid = 1'b0, exp_succ = 1'b0, exp_commit = 1'b0;
    logic [STAT_W-1:0] exp_status = '0;
    string             exp_tag = "R1";
    string             phase = "reset";
    bit                started = 0;
    int                compared = 0, mismatched = 0;
    bit                done = 0;

    function automatic int find_line(input logic [ADDR_W-1:0] ln);
        for (int i = 0; i < mq.size(); i++)
            if (mq[i].line == ln) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            mq.delete();
            exp_valid = 0; exp_succ = 0; exp_commit = 0; exp_status = '0;
            exp_tag = "R1";
        end else begin
            int idx;
            resv_t nr;
            if (loss_valid) begin
                idx = find_line(loss_line);
                if (idx >= 0) mq.delete(idx);          // R7: loss first
            end
            exp_valid = cmp_valid;
            exp_succ = 0; exp_commit = 0; exp_status = '0;
            exp_tag = "R2";
            if (cmp_valid) begin
                idx = find_line(cmp_line);
                if (!cmp_line_present) begin
                    exp_tag    = "R8";
                    exp_succ   = 1;
                    exp_commit = (cmp_kind == 2) || (cmp_kind == 3);
                    exp_status = STAT_W'(cmp_kind == 2);
                end else begin
                    case (cmp_kind)
                        2'd0: begin exp_tag = "R9"; exp_succ = 1; end
                        2'd1: begin
                            exp_tag = "R3"; exp_succ = 1;
                            if (idx >= 0) mq.delete(idx);   // R10 refresh
                            else if (mq.size() == N_RES) void'(mq.pop_front()); // R11
                            nr.line = cmp_line; nr.owner = cmp_owner;
                            mq.push_back(nr);
                        end
                        2'd2: begin
                            exp_tag = "R4";
                            exp_succ = (idx >= 0) && (mq[idx].owner == cmp_owner);
                            exp_commit = exp_succ;
                            exp_status = STAT_W'(exp_succ);
                            if (idx >= 0) mq.delete(idx);   // R5
                        end
                        default: begin
                            exp_tag = "R6"; exp_succ = 1; exp_commit = 1;
                            if (idx >= 0 && mq[idx].owner == cmp_owner) mq.delete(idx);
                        end
                    endcase
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            compared++;
            if (rsp_valid !== exp_valid ||
                (exp_valid && (rsp_success !== exp_succ || rsp_commit !== exp_commit ||
                               rsp_status !== exp_status))) begin
                mismatched++;
                $display("FAIL %s [%s] t=%0t valid/success/commit/status = %b/%b/%b/%0d expected %b/%b/%b/%0d",
                         exp_tag, phase, $time, rsp_valid, rsp_success, rsp_commit, rsp_status,
                         exp_valid, exp_succ, exp_commit, exp_status);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic drive(input logic v, input logic [1:0] k, input int ln, input int ow,
                         input logic pres, input logic lv, input int ll);
        cmp_valid = v; cmp_kind = k; cmp_line = ADDR_W'(ln); cmp_owner = OWNER_W'(ow);
        cmp_line_present = pres; loss_valid = lv; loss_line = ADDR_W'(ll);
        @(negedge clk);
    endtask

    task automatic op(input logic [1:0] k, input int ln, input int ow);
        drive(1'b1, k, ln, ow, 1'b1, 1'b0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 2'd0, 0, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        phase = "R1 sc after reset";   op(2, 5, 1); idle(1);
        phase = "R3 R4 R5 ll-sc pair"; op(1, 5, 1); op(2, 5, 1); op(2, 5, 1); idle(1);
        phase = "R4 R5 owner mismatch"; op(1, 6, 1); op(2, 6, 2); op(2, 6, 1); idle(1);
        phase = "R6 foreign store";    op(1, 7, 1); op(3, 7, 2); op(2, 7, 1);
        phase = "R6 own store";        op(1, 7, 1); op(3, 7, 1); op(2, 7, 1); idle(1);
        phase = "R7 loss";             op(1, 8, 1); drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 8); op(2, 8, 1);
        phase = "R7 loss same cycle";  op(1, 9, 1); drive(1'b1, 2, 9, 1, 1'b1, 1'b1, 9); idle(1);
        phase = "R7 loss other line";  op(1, 9, 1); drive(1'b1, 2, 9, 1, 1'b1, 1'b1, 3); idle(1);
        phase = "R8 absent line";      op(1, 10, 1); drive(1'b1, 2, 10, 2, 1'b0, 1'b0, 0);
                                       drive(1'b1, 3, 10, 1, 1'b0, 1'b0, 0);
                                       drive(1'b1, 1, 10, 2, 1'b0, 1'b0, 0); op(2, 10, 1);
        phase = "R9 read";             op(1, 11, 1); op(0, 11, 2); op(0, 11, 1); op(2, 11, 1);
        phase = "R10 retag";           op(1, 12, 1); op(1, 12, 2); op(2, 12, 1);
                                       op(1, 12, 1); op(1, 12, 2); op(2, 12, 2); idle(1);
        phase = "R11 evict oldest";    op(1, 20, 1); op(1, 21, 1); op(1, 22, 1); op(1, 23, 1);
                                       op(1, 24, 1); op(2, 20, 1); op(2, 21, 1); idle(1);
        phase = "R11 evict after refresh";
                                       op(1, 30, 1); op(1, 31, 1); op(1, 32, 1); op(1, 33, 1);
                                       op(1, 30, 2); op(1, 34, 1); op(2, 31, 1); op(2, 30, 2);
                                       op(2, 32, 1); idle(2);
        phase = "mixed traffic R2-R11";
        for (int i = 0; i < 4000; i++)
            drive(($urandom % 4) != 0, 2'($urandom % 4), 40 + int'($urandom % 6),
                  int'($urandom % 3), ($urandom % 8) != 0, ($urandom % 5) == 0,
                  40 + int'($urandom % 6));
        idle(3);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            mismatched++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule